// File: doc/BRIEF.md
# Oscillation Settle Timer

This block measures how long a high-speed oscillator has been running since it was last started. It counts oscillator clock edges from the most recent clear and shows its progress in an 8-bit read-only status byte. The byte fills like a thermometer: the top bit sets first, and each lower flag follows at a later power-of-two milestone. A `stable_o` flag reports that the wait length chosen by a 3-bit select has passed.

The clear input is pulsed whenever the oscillator stops, restarts, or the system enters stop mode. The block then restarts from zero. Once the chosen wait is reached, the counter freezes, so the flags for longer milestones stay at zero. Software reads the byte, or one bit of it, through a registered read port. The select must be held constant between two clears.

Top module: `osc_settle_timer`

## Requirements
- R1: Counting edges are rising clock edges with `clr_i` low since the last clear or reset. Status bit 7 sets after 2048 counting edges, bit 6 after 8192, bit 5 after 16384, bit 4 after 32768 and bit 3 after 65536. No flag marks 4096.
- R2: Status bits 2, 1 and 0 always read 0.
- R3: Each flag, once set, stays set until a clear. A flag never sets while the flag above it (the next shorter milestone, at the next higher bit) is still 0.
- R4: Reset (`rst_n` low) or `clr_i` high at an edge makes the status 00h and `stable_o` 0 after that edge. Counting then restarts from zero.
- R5: Counting stops at the selected wait length. Flags for longer milestones stay 0 however long the clock keeps running.
- R6: `wait_sel_i` selects the wait length: 0 selects 2048 edges, 1 selects 8192, 2 selects 16384, 3 selects 32768 and 4 selects 65536. Values 5, 6 and 7 also select 65536. `stable_o` rises on the same edge as the selected flag and stays high until the next clear.
- R7: If `clr_i` is high on the edge where a milestone would be reached, the clear wins: the flag does not set and the status is 00h.
- R8: `rd_en_i` high at an edge copies the pre-edge status byte into `rd_byte_o`. With `rd_en_i` low, `rd_byte_o` and `rd_bit_o` hold their values. Both are 0 after reset.
- R9: On the same read edge, `rd_bit_o` takes the pre-edge status bit whose index is given by `rd_bit_idx_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-speed oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear (stop entry, oscillator stop or restart) |
| wait_sel_i | input | 3 | Wait-length select |
| rd_en_i | input | 1 | Read strobe |
| rd_bit_idx_i | input | 3 | Bit index for the single-bit read |
| status_o | output | 8 | Live status byte |
| stable_o | output | 1 | Selected wait has elapsed |
| rd_byte_o | output | 8 | Byte captured by the last read |
| rd_bit_o | output | 1 | Bit captured by the last read |

## Verification
Two events can fall on the same edge: a clear and the counter reaching a milestone. The bench provokes this by counting exactly 2047 edges with the shortest wait selected and then raising `clr_i` on the 2048th edge. It expects 00h and a low `stable_o` afterwards, and then a normal fill on the following run. A read strobe on the milestone edge is a second coincidence. Random read strobes throughout every run check that the captured byte is the status from before that edge, not after it.

// File: rtl/osc_settle_pkg.sv
package osc_settle_pkg;

  localparam int unsigned NUM_FLAGS = 5;
  localparam int unsigned STAT_W    = 8;
  localparam int unsigned SEL_W     = 3;

  typedef logic [SEL_W-1:0] wsel_t;

  // log2 of the edge count for flag number idx (flag 0 is the shortest)
  function automatic int unsigned flag_log(input int unsigned idx);
    case (idx)
      0:       return 11;
      1:       return 13;
      2:       return 14;
      3:       return 15;
      default: return 16;
    endcase
  endfunction

  // map a select code onto the flag that ends the wait
  function automatic int unsigned sel_to_flag(input wsel_t sel);
    if (int'(sel) >= NUM_FLAGS - 1) return NUM_FLAGS - 1;
    return int'(sel);
  endfunction

endpackage

// File: rtl/osc_settle_count.sv
module osc_settle_count
  import osc_settle_pkg::*;
#(
  parameter int unsigned CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  wsel_t            sel,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic [CNT_W-1:0] limit_o
);

  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    limit_o = CNT_W'(1) << flag_log(sel_to_flag(sel));
  end

  // saturating count: stops at the selected limit, never wraps
  always_comb begin
    if (clr)                 cnt_nxt_o = '0;
    else if (cnt_q < limit_o) cnt_nxt_o = cnt_q + CNT_W'(1);
    else                     cnt_nxt_o = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt_o;
  end

endmodule

// File: rtl/osc_settle_flags.sv
module osc_settle_flags
  import osc_settle_pkg::*;
#(
  parameter int unsigned CNT_W = 17,
  parameter int unsigned NFLAG = NUM_FLAGS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] limit,
  output logic [NFLAG-1:0] flags_o,
  output logic             stable_o
);

  logic [NFLAG-1:0] flag_q;
  logic             stable_q;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    localparam logic [CNT_W-1:0] THRESH = CNT_W'(1) << flag_log(i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag_q[i] <= 1'b0;
      else if (clr) flag_q[i] <= 1'b0;
      else          flag_q[i] <= flag_q[i] | (cnt_nxt >= THRESH);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   stable_q <= 1'b0;
    else if (clr) stable_q <= 1'b0;
    else          stable_q <= stable_q | (cnt_nxt >= limit);
  end

  assign flags_o  = flag_q;
  assign stable_o = stable_q;

endmodule

// File: rtl/osc_settle_rdport.sv
module osc_settle_rdport #(
  parameter int unsigned STAT_W = 8,
  localparam int unsigned IDX_W = $clog2(STAT_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [STAT_W-1:0] status,
  output logic [STAT_W-1:0] rd_byte_o,
  output logic              rd_bit_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_byte_o <= '0;
      rd_bit_o  <= 1'b0;
    end else if (rd_en) begin
      rd_byte_o <= status;
      rd_bit_o  <= status[rd_idx];
    end
  end

endmodule

// File: rtl/osc_settle_timer.sv
module osc_settle_timer
  import osc_settle_pkg::*;
#(
  parameter int unsigned CNT_W = 17,
  localparam int unsigned IDX_W = $clog2(STAT_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic [SEL_W-1:0]  wait_sel_i,
  input  logic              rd_en_i,
  input  logic [IDX_W-1:0]  rd_bit_idx_i,
  output logic [STAT_W-1:0] status_o,
  output logic              stable_o,
  output logic [STAT_W-1:0] rd_byte_o,
  output logic              rd_bit_o
);

  logic [CNT_W-1:0]     cnt_nxt;
  logic [CNT_W-1:0]     limit;
  logic [NUM_FLAGS-1:0] flags;

  osc_settle_count #(.CNT_W(CNT_W)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr_i),
    .sel       (wait_sel_i),
    .cnt_nxt_o (cnt_nxt),
    .limit_o   (limit)
  );

  osc_settle_flags #(.CNT_W(CNT_W), .NFLAG(NUM_FLAGS)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr_i),
    .cnt_nxt  (cnt_nxt),
    .limit    (limit),
    .flags_o  (flags),
    .stable_o (stable_o)
  );

  // shortest milestone at the top bit, later ones below, low bits unused
  always_comb begin
    status_o = '0;
    for (int i = 0; i < NUM_FLAGS; i++) begin
      status_o[STAT_W-1-i] = flags[i];
    end
  end

  osc_settle_rdport #(.STAT_W(STAT_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en_i),
    .rd_idx    (rd_bit_idx_i),
    .status    (status_o),
    .rd_byte_o (rd_byte_o),
    .rd_bit_o  (rd_bit_o)
  );

endmodule

// File: rtl/osc_settle_chk.sv
module osc_settle_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clr_i,
  input logic [2:0] wait_sel_i,
  input logic       rd_en_i,
  input logic [7:0] status_o,
  input logic       stable_o,
  input logic [7:0] rd_byte_o,
  input logic       rd_bit_o
);

  p_low_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[2:0] == 3'b000);

  p_thermo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[7:3] & ~{1'b1, status_o[7:4]}) == 5'b00000);

  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((status_o & $past(status_o)) == $past(status_o)));

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (status_o == 8'h00 && !stable_o));

  p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && stable_o && $stable(wait_sel_i)) |=> $stable(status_o));

  p_stable_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && stable_o) |=> stable_o);

  p_stable_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stable_o |-> status_o[7]);

  p_rd_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> (rd_byte_o == $past(status_o)));

  p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> ($stable(rd_byte_o) && $stable(rd_bit_o)));

endmodule

bind osc_settle_timer osc_settle_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clr_i      (clr_i),
  .wait_sel_i (wait_sel_i),
  .rd_en_i    (rd_en_i),
  .status_o   (status_o),
  .stable_o   (stable_o),
  .rd_byte_o  (rd_byte_o),
  .rd_bit_o   (rd_bit_o)
);

// File: tb/osc_settle_timer_bench.sv
module osc_settle_timer_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr_i = 1'b0;
  logic [2:0] wait_sel_i = 3'd0;
  logic       rd_en_i = 1'b0;
  logic [2:0] rd_bit_idx_i = 3'd0;
  logic [7:0] status_o;
  logic       stable_o;
  logic [7:0] rd_byte_o;
  logic       rd_bit_o;

  int          n_chk = 0;
  int          n_err = 0;
  int unsigned n_el = 0;
  logic [7:0]  e_rb = 8'h00;
  logic        e_rbit = 1'b0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  osc_settle_timer u_osc_settle_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_i        (clr_i),
    .wait_sel_i   (wait_sel_i),
    .rd_en_i      (rd_en_i),
    .rd_bit_idx_i (rd_bit_idx_i),
    .status_o     (status_o),
    .stable_o     (stable_o),
    .rd_byte_o    (rd_byte_o),
    .rd_bit_o     (rd_bit_o)
  );

  // R6 encoding
  function automatic int unsigned exp_lim(input logic [2:0] sel);
    case (sel)
      3'd0:    return 2048;
      3'd1:    return 8192;
      3'd2:    return 16384;
      3'd3:    return 32768;
      default: return 65536;
    endcase
  endfunction

  // R1, R2, R5: flags from elapsed edges clipped at the selected wait
  function automatic logic [7:0] exp_stat(input int unsigned n, input logic [2:0] sel);
    int unsigned e;
    logic [7:0]  r;
    e = (n < exp_lim(sel)) ? n : exp_lim(sel);
    r = 8'h00;
    r[7] = (e >= 2048);
    r[6] = (e >= 8192);
    r[5] = (e >= 16384);
    r[4] = (e >= 32768);
    r[3] = (e >= 65536);
    return r;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %02h expected %02h at n=%0d", tag, act, exp, n_el);
    end
  endtask

  // one clock: drive at negedge, update model for the edge, check at next negedge
  task automatic cyc(input logic clr, input logic [2:0] sel, input logic rd,
                     input logic [2:0] idx, input string tag);
    logic [7:0] pre;
    pre = exp_stat(n_el, sel);
    clr_i = clr; wait_sel_i = sel; rd_en_i = rd; rd_bit_idx_i = idx;
    if (rd) begin e_rb = pre; e_rbit = pre[idx]; end
    if (clr) n_el = 0;
    else if (n_el < 32'd1000000) n_el++;
    @(negedge clk);
    chk(tag, status_o, exp_stat(n_el, sel));
    chk("R6", {7'd0, stable_o}, {7'd0, (n_el >= exp_lim(sel))});
    chk("R8", rd_byte_o, e_rb);
    chk("R9", {7'd0, rd_bit_o}, {7'd0, e_rbit});
  endtask

  task automatic run(input int unsigned cycles, input logic [2:0] sel, input string tag);
    for (int unsigned i = 0; i < cycles; i++) begin
      cyc(1'b0, sel, ($urandom_range(0, 3) == 0), 3'($urandom_range(0, 7)), tag);
    end
  endtask

  initial begin
    #(8 * 199000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R4: reset state
    chk("R4", status_o, 8'h00);
    chk("R4", {7'd0, stable_o}, 8'h00);
    chk("R8", rd_byte_o, 8'h00);
    rst_n = 1'b1;
    n_el = 0;

    // R1 shortest wait, then R5 freeze
    run(2048, 3'd0, "R1");
    run(40, 3'd0, "R5");
    chk("R5", status_o, 8'h80);
    cyc(1'b1, 3'd0, 1'b0, 3'd0, "R4");

    // R7: clear lands on the milestone edge
    run(2047, 3'd0, "R1");
    chk("R7", status_o, 8'h00);
    cyc(1'b1, 3'd0, 1'b0, 3'd0, "R7");
    chk("R7", status_o, 8'h00);
    chk("R7", {7'd0, stable_o}, 8'h00);
    run(2050, 3'd0, "R4");
    chk("R4", status_o, 8'h80);
    cyc(1'b1, 3'd1, 1'b1, 3'd7, "R4");

    run(8200, 3'd1, "R1");
    chk("R1", status_o, 8'hC0);
    cyc(1'b1, 3'd2, 1'b0, 3'd0, "R4");
    run(16400, 3'd2, "R1");
    chk("R1", status_o, 8'hE0);
    cyc(1'b1, 3'd4, 1'b0, 3'd0, "R4");
    run(65540, 3'd4, "R1");
    run(30, 3'd4, "R5");
    chk("R1", status_o, 8'hF8);
    cyc(1'b1, 3'd6, 1'b0, 3'd0, "R4");
    run(65536, 3'd6, "R6");
    chk("R6", status_o, 8'hF8);
    chk("R6", {7'd0, stable_o}, 8'h01);
    cyc(1'b0, 3'd6, 1'b1, 3'd3, "R9");
    chk("R9", {7'd0, rd_bit_o}, 8'h01);
    cyc(1'b0, 3'd6, 1'b1, 3'd2, "R2");
    chk("R2", {7'd0, rd_bit_o}, 8'h00);

    // random segments, wait select held per segment
    for (int s = 0; s < 20; s++) begin
      logic [2:0] sel;
      int unsigned len;
      sel = 3'($urandom_range(0, 7));
      len = $urandom_range(1, 1200);
      cyc(1'b1, sel, 1'b0, 3'd0, "R4");
      for (int unsigned i = 0; i < len; i++) begin
        cyc(($urandom_range(0, 499) == 0), sel, ($urandom_range(0, 1) == 0),
            3'($urandom_range(0, 7)), "R3");
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule